// File: doc/BRIEF.md
# Serial Line Break and Idle Monitor

This block watches one asynchronous serial line. It runs beside the frame receiver and does not depend on it. An optional polarity flip is applied to the line, and then the line passes through a synchronizer. After that, the block times low and high stretches against the length of one character frame. The frame length is worked out from the bit period and the current format settings: data width, parity on or off, and stop bits in half-bit steps. The settings can change while the block runs.

When a low stretch lasts at least one frame length, the block reports a break. The report comes when the line returns high, and it carries the measured length of the low stretch. A receiver can use this break pulse to fall back to its wait-for-start state. When the line stays high, the block sends an idle pulse once per frame length. A companion receiver can restart the idle window by signalling that it has reached the computed end of a received frame.

Top module: `line_break_idle_mon`

## Requirements
- R1: The frame length in clock cycles is ceil(bit_period × (2 × (1 + data_bits + parity_en) + stop_halves) / 2). Here data_bits is clamped to 5..9 and stop_halves (0..4, counting half stop bits) is clamped to 4.
- R2: A low stretch is a break only if the number of clock cycles with the line low, counted from the falling edge to the next rising edge, is at least the frame length. A shorter low stretch gives no break.
- R3: The break is reported by a single-cycle brk_pulse when the line rises. The pulse is never issued while the line is still low. Results come out SYNC_STAGES + 1 cycles after the line pins.
- R4: brk_len holds the low-stretch length of the most recent break and changes only together with brk_pulse. The length saturates at 2^CNT_W − 1 and does not wrap.
- R5: Any low level cancels idle timing. Idle timing starts again with the first cycle the line is seen high. A high stretch shorter than one frame length gives no idle pulse.
- R6: While the line stays high, idle_pulse fires once every frame length: the first pulse after that many high cycles, and each later one exactly one frame length after the one before.
- R7: A frame_end strobe restarts the idle window. The next idle pulse comes exactly frame-length cycles after the edge that samples the strobe.
- R8: With invert set, the line is taken as active-high. A high stretch on the pin is then timed as a low stretch, and the reverse.
- R9: After reset, brk_pulse, idle_pulse and brk_len are zero. The line is assumed idle until it is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw serial line |
| invert | input | 1 | Flip line polarity before timing |
| bit_period | input | BIT_W | Clock cycles per serial bit |
| data_bits | input | 4 | Data bits per character (5..9) |
| parity_en | input | 1 | A parity bit is present |
| stop_halves | input | 3 | Stop bits in half-bit units (0..4) |
| frame_end | input | 1 | Receiver reached computed end of a frame |
| brk_pulse | output | 1 | One-cycle break report |
| brk_len | output | CNT_W | Low-stretch length of last break, saturating |
| idle_pulse | output | 1 | One-cycle idle-frame report |

## Verification
On every cycle the assertions check these properties:
- A break pulse lasts one cycle.
- A break pulse follows a low-to-high change on the conditioned line.
- The reported length is never below the frame length in force when the break was decided.
- brk_len changes only with a pulse.
- An idle pulse comes only after a high level.

Only the bench scenarios can show the exact frame-length threshold for each format, the idle pulse spacing, the restart timing after frame_end, the polarity flip and the saturation of very long breaks.

// File: rtl/lbi_pkg.sv
package lbi_pkg;

   localparam int UNIT_W  = 5;   // holds up to 2*(1+9+1)+4 = 26 half-bit units
   localparam int DB_MIN  = 5;
   localparam int DB_MAX  = 9;
   localparam int SH_MAX  = 4;

   typedef struct packed {
      logic [3:0] data_bits;
      logic       parity_en;
      logic [2:0] stop_halves;
   } lbi_fmt_t;

   // Number of half-bit units in one frame, with clamped settings.
   function automatic logic [UNIT_W-1:0] frame_units(lbi_fmt_t f);
      logic [UNIT_W-1:0] db;
      logic [UNIT_W-1:0] sh;
      if (f.data_bits < 4'(DB_MIN))      db = UNIT_W'(DB_MIN);
      else if (f.data_bits > 4'(DB_MAX)) db = UNIT_W'(DB_MAX);
      else                               db = UNIT_W'(f.data_bits);
      sh = (f.stop_halves > 3'(SH_MAX)) ? UNIT_W'(SH_MAX) : UNIT_W'(f.stop_halves);
      return UNIT_W'(2) * (UNIT_W'(1) + db + UNIT_W'(f.parity_en)) + sh;
   endfunction

endpackage

// File: rtl/lbi_framelen.sv
module lbi_framelen
   import lbi_pkg::*;
#(
   parameter int BIT_W   = 16,
   parameter int LEN_W   = BIT_W + 4,
   parameter bit REG_LEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BIT_W-1:0] bit_period,
   input  lbi_fmt_t         fmt,
   output logic [LEN_W-1:0] frame_len
);

   localparam int PROD_W = BIT_W + UNIT_W;

   logic [UNIT_W-1:0] units;
   logic [PROD_W-1:0] prod;
   logic [LEN_W-1:0]  len_next;

   always_comb begin
      units    = frame_units(fmt);
      prod     = PROD_W'(bit_period) * PROD_W'(units);
      // half-bit units: divide by two, rounding up
      len_next = LEN_W'((prod + PROD_W'(1)) >> 1);
   end

   generate
      if (REG_LEN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) frame_len <= '1;
            else        frame_len <= len_next;
         end
      end else begin : g_comb
         assign frame_len = len_next;
      end
   endgenerate

endmodule

// File: rtl/lbi_linecond.sv
module lbi_linecond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic invert,
   output logic lvl,
   output logic rise,
   output logic fall
);

   logic flipped;
   logic lvl_d;

   assign flipped = line_in ^ invert;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign lvl = flipped;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], flipped};
         end
         assign lvl = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b1;
      else        lvl_d <= lvl;
   end

   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/lbi_brktimer.sv
module lbi_brktimer #(
   parameter int LEN_W = 20,
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             rise,
   input  logic             fall,
   input  logic [LEN_W-1:0] frame_len,
   output logic             brk_pulse,
   output logic [CNT_W-1:0] brk_len
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] low_cnt;
   logic             long_enough;

   assign long_enough = (low_cnt >= CNT_W'(frame_len)) && (low_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         brk_pulse <= 1'b0;
         brk_len   <= '0;
      end else begin
         brk_pulse <= 1'b0;
         if (!lvl) begin
            if (fall)                    low_cnt <= CNT_W'(1);
            else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + CNT_W'(1);
         end else if (rise) begin
            if (long_enough) begin
               brk_pulse <= 1'b1;
               brk_len   <= low_cnt;
            end
            low_cnt <= '0;
         end
      end
   end

endmodule

// File: rtl/lbi_idletimer.sv
module lbi_idletimer #(
   parameter int LEN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             restart,
   input  logic [LEN_W-1:0] frame_len,
   output logic             idle_pulse
);

   logic [LEN_W-1:0] hi_cnt;
   logic [LEN_W:0]   hi_next;

   assign hi_next = {1'b0, hi_cnt} + (LEN_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt     <= '0;
         idle_pulse <= 1'b0;
      end else begin
         idle_pulse <= 1'b0;
         if (!lvl) begin
            hi_cnt <= '0;
         end else if (restart) begin
            hi_cnt <= '0;
         end else if (hi_next >= {1'b0, frame_len}) begin
            idle_pulse <= 1'b1;
            hi_cnt     <= '0;
         end else begin
            hi_cnt <= hi_next[LEN_W-1:0];
         end
      end
   end

endmodule

// File: rtl/line_break_idle_mon.sv
module line_break_idle_mon
   import lbi_pkg::*;
#(
   parameter int BIT_W       = 16,
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_LEN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_in,
   input  logic             invert,
   input  logic [BIT_W-1:0] bit_period,
   input  logic [3:0]       data_bits,
   input  logic             parity_en,
   input  logic [2:0]       stop_halves,
   input  logic             frame_end,
   output logic             brk_pulse,
   output logic [CNT_W-1:0] brk_len,
   output logic             idle_pulse
);

   localparam int LEN_W = BIT_W + 4;

   generate
      if (BIT_W < 1) begin : g_bad_bitw
         $error("BIT_W must be at least 1");
      end
      if (CNT_W < LEN_W) begin : g_bad_cntw
         $error("CNT_W must cover the widest frame length");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   lbi_fmt_t         fmt;
   logic [LEN_W-1:0] frame_len;
   logic             line_lvl;
   logic             line_rise;
   logic             line_fall;

   assign fmt = '{data_bits: data_bits, parity_en: parity_en, stop_halves: stop_halves};

   lbi_framelen #(.BIT_W(BIT_W), .LEN_W(LEN_W), .REG_LEN(REG_LEN)) u_len (
      .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .fmt(fmt), .frame_len(frame_len)
   );

   lbi_linecond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
      .lvl(line_lvl), .rise(line_rise), .fall(line_fall)
   );

   lbi_brktimer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_brk (
      .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .rise(line_rise), .fall(line_fall),
      .frame_len(frame_len), .brk_pulse(brk_pulse), .brk_len(brk_len)
   );

   lbi_idletimer #(.LEN_W(LEN_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .restart(frame_end),
      .frame_len(frame_len), .idle_pulse(idle_pulse)
   );

endmodule

// File: rtl/line_break_idle_mon_chk.sv
module line_break_idle_mon_chk #(
   parameter int LEN_W = 20,
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_lvl,
   input logic [LEN_W-1:0] frame_len,
   input logic             brk_pulse,
   input logic [CNT_W-1:0] brk_len,
   input logic             idle_pulse
);

   // R2
   brk_len_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> (brk_len >= CNT_W'($past(frame_len))));

   // R3
   brk_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> ($past(line_lvl) && !$past(line_lvl, 2)));

   // R3
   brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> !brk_pulse);

   // R4
   brk_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_len != $past(brk_len)) |-> brk_pulse);

   // R5
   idle_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> $past(line_lvl));

endmodule

bind line_break_idle_mon line_break_idle_mon_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .frame_len(frame_len),
   .brk_pulse(brk_pulse), .brk_len(brk_len), .idle_pulse(idle_pulse)
);

// File: tb/tb_line_break_idle_mon.sv
module tb_line_break_idle_mon;

   localparam int BIT_W = 6;
   localparam int CNT_W = 12;
   localparam int SAT   = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             line_in = 1'b1;
   logic             invert = 1'b0;
   logic [BIT_W-1:0] bit_period = 6'd4;
   logic [3:0]       data_bits = 4'd8;
   logic             parity_en = 1'b0;
   logic [2:0]       stop_halves = 3'd2;
   logic             frame_end = 1'b0;
   logic             brk_pulse;
   logic [CNT_W-1:0] brk_len;
   logic             idle_pulse;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int cyc = 0;
   int brk_cnt = 0;
   int idle_cnt = 0;
   int last_brk_len = 0;
   int last_idle_cyc = -1;
   int prev_idle_cyc = -1;

   always #2 clk = ~clk;   // 250 MHz

   line_break_idle_mon #(.BIT_W(BIT_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
      .bit_period(bit_period), .data_bits(data_bits), .parity_en(parity_en),
      .stop_halves(stop_halves), .frame_end(frame_end),
      .brk_pulse(brk_pulse), .brk_len(brk_len), .idle_pulse(idle_pulse)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && brk_pulse) begin
         brk_cnt      <= brk_cnt + 1;
         last_brk_len <= int'(brk_len);
      end
      if (rst_n && idle_pulse) begin
         idle_cnt      <= idle_cnt + 1;
         prev_idle_cyc <= last_idle_cyc;
         last_idle_cyc <= cyc;
      end
   end

   function automatic int exp_frame(int bp, int db, int par, int sh);
      int d;
      int s;
      d = (db < 5) ? 5 : ((db > 9) ? 9 : db);
      s = (sh > 4) ? 4 : sh;
      return (bp * (2 * (1 + d + par) + s) + 1) / 2;
   endfunction

   function automatic int exp_len(int n);
      return (n > SAT) ? SAT : n;
   endfunction

   task automatic check(string req, int act, int expv, string what);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic set_fmt(int bp, int db, int par, int sh);
      @(negedge clk);
      bit_period  = BIT_W'(bp);
      data_bits   = 4'(db);
      parity_en   = 1'(par);
      stop_halves = 3'(sh);
      settle(3);
   endtask

   // Hold the active-low level for n cycles, then release; return pulses seen.
   task automatic low_stretch(int n, output int during, output int after, output int len);
      int b0;
      @(negedge clk);
      #1;
      b0 = brk_cnt;
      line_in = invert;
      repeat (n) @(negedge clk);
      #1;
      during = brk_cnt - b0;
      line_in = ~invert;
      settle(6);
      after = brk_cnt - b0;
      len = last_brk_len;
   endtask

   task automatic break_case(string req, int n, int f);
      int during;
      int after;
      int len;
      low_stretch(n, during, after, len);
      check("R3", during, 0, "pulses while low");
      check(req, after, (n >= f) ? 1 : 0, $sformatf("break count low=%0d frame=%0d", n, f));
      if (n >= f) check("R4", len, exp_len(n), "break length");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int f;
      int ia;
      int h;
      int t0;
      void'($urandom(32'd1234));
      settle(3);
      // R9 reset state
      check("R9", int'(brk_pulse), 0, "brk_pulse in reset");
      check("R9", int'(idle_pulse), 0, "idle_pulse in reset");
      check("R9", int'(brk_len), 0, "brk_len in reset");
      @(negedge clk);
      rst_n = 1'b1;
      settle(2);

      // R1 directed: 5 cycles/bit, 8 data, parity, 1.5 stop -> 57.5 -> 58
      set_fmt(5, 8, 1, 3);
      f = exp_frame(5, 8, 1, 3);
      check("R1", f, 58, "bench frame formula");
      break_case("R1", 57, f);
      break_case("R1", 58, f);
      // R2 boundary on another format, clamped data width 12 -> 9
      set_fmt(3, 12, 0, 1);
      f = exp_frame(3, 12, 0, 1);
      break_case("R2", f - 1, f);
      break_case("R2", f, f);
      break_case("R2", 2, f);

      // R2 randomized formats and lengths around the threshold
      for (int i = 0; i < 40; i++) begin
         int bp;
         int db;
         int par;
         int sh;
         int n;
         bp  = 2 + int'($urandom_range(10));
         db  = 5 + int'($urandom_range(4));
         par = int'($urandom_range(1));
         sh  = int'($urandom_range(4));
         set_fmt(bp, db, par, sh);
         f = exp_frame(bp, db, par, sh);
         n = f - 3 + int'($urandom_range(6));
         if (n < 1) n = 1;
         break_case("R2", n, f);
      end

      // R4 saturation with a very long low stretch
      set_fmt(2, 5, 0, 2);
      f = exp_frame(2, 5, 0, 2);
      break_case("R4", 4300, f);

      // R5/R6 idle counting over a known high stretch
      set_fmt(4, 7, 0, 2);
      f = exp_frame(4, 7, 0, 2);
      for (int k = 0; k < 3; k++) begin
         h = k * f + f / 2;
         @(negedge clk);
         line_in = invert;
         settle(4);
         ia = idle_cnt;
         line_in = ~invert;
         repeat (h) @(negedge clk);
         line_in = invert;
         settle(4);
         check((k == 0) ? "R5" : "R6", idle_cnt - ia, k, $sformatf("idle pulses over %0d high", h));
         line_in = ~invert;
      end
      // R6 spacing while held high
      settle(4 * f);
      check("R6", last_idle_cyc - prev_idle_cyc, f, "idle spacing");

      // R7 frame_end restarts the window
      settle(3 + int'($urandom_range(5)));
      frame_end = 1'b1;
      t0 = cyc;
      @(negedge clk);
      frame_end = 1'b0;
      while (last_idle_cyc <= t0 + 1) @(negedge clk);
      #1;
      check("R7", last_idle_cyc - (t0 + 1), f, "idle after frame_end");

      // R8 inverted polarity: idle pin level becomes low
      @(negedge clk);
      invert  = 1'b1;
      line_in = 1'b0;
      settle(4);
      set_fmt(3, 6, 1, 4);
      f = exp_frame(3, 6, 1, 4);
      break_case("R8", f + 5, f);
      break_case("R8", f - 2, f);
      @(negedge clk);
      invert  = 1'b0;
      line_in = 1'b1;
      settle(4);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule